// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block connects an on-chip bus master to an external asynchronous static RAM of 128K words by 16 bits. The master presents one request at a time through a valid/ready handshake: a read/write flag, a 17-bit word address, 16 bits of write data and a 2-bit byte mask. A read returns its data with a one-clock valid pulse.

On the memory side the controller drives the address, five active-low strobes (chip enable, output enable, write enable, lower and upper byte enable) and a data bus. Each byte lane of the data bus has its own output enable, so the pad ring can tri-state the lanes independently. Every access holds its strobes steady for N+1 clocks. N comes from a wait-state input that is sampled when the request is accepted, so one controller can serve any speed grade of the memory.

Between accesses the controller deselects the memory for at least one clock. During that clock it drives no data lane, so write data never collides with read data.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset, and whenever no access is in progress, chip enable, output enable, write enable and both byte enables are high (1), no data lane is driven (lane enable 0), ready is 1 and response valid is 0.
- R2: An access with a non-zero mask holds chip enable low for exactly N+1 consecutive clocks. N is the value of the wait-state input in the cycle the request is accepted.
- R3: During a read access, output enable is low and write enable is high. Response valid is high for one clock, in the cycle right after the last access clock, and it carries the data bus value from that last clock.
- R4: During a write access, write enable is low and output enable is high. Only the lanes whose mask bit is 1 are written into memory.
- R5: Mask bit 0 selects the lower lane (data bits 7:0, byte enable bit 0) and mask bit 1 selects the upper lane (bits 15:8, byte enable bit 1). A selected lane has its byte enable low for the whole access. An unselected lane keeps it high.
- R6: A data lane is driven (lane enable bit 1) only while write enable is low, and only if that lane is selected. During a read no lane is driven.
- R7: Read data bits that belong to an unselected lane are returned as zero.
- R8: A request with mask 00 completes without asserting chip enable. If it is a read, response valid pulses in the next clock with data 0x0000. If it is a write, there is no pulse and memory is unchanged. Ready stays 1.
- R9: Ready is 0 for the whole of a non-zero-mask access. Before the next access starts, chip enable returns high for at least one clock.
- R10: The address output stays stable in every cycle in which write enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wait_cfg_i | input | 4 | Wait states N; each access lasts N+1 clocks |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Controller can accept a request |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 17 | Word address |
| req_wdata_i | input | 16 | Write data |
| req_mask_i | input | 2 | Byte mask, bit 0 lower lane, bit 1 upper lane |
| rsp_valid_o | output | 1 | One-clock read-data valid |
| rsp_rdata_o | output | 16 | Read data, unselected lanes zero |
| sram_addr_o | output | 17 | Memory address |
| sram_ce_no | output | 1 | Chip enable, active low |
| sram_oe_no | output | 1 | Output enable, active low |
| sram_we_no | output | 1 | Write enable, active low |
| sram_be_no | output | 2 | Byte enables, active low, bit 0 lower, bit 1 upper |
| sram_dq_o | output | 16 | Data toward memory |
| sram_dq_oe_o | output | 2 | Per-lane drive enable for the data pads |
| sram_dq_i | input | 16 | Data from memory |

## Verification
The bench drives word, lower-byte and upper-byte accesses against a behavioural memory that returns a poison byte on every lane it is not enabling. A read whose lane masking is wrong therefore shows up as a wrong byte instead of a matching zero. Mixed random traffic writes with one mask and reads back with another, which separates per-lane write gating from per-lane read zeroing. Wait counts of 0 and the maximum check where the access ends and where the data is sampled. Zero-mask reads and writes confirm that chip enable never falls and that the stored contents survive.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;
  typedef enum logic [0:0] {
    SEQ_IDLE   = 1'b0,
    SEQ_ACCESS = 1'b1
  } seq_state_e;

  localparam int unsigned LANE_BITS = 8;
endpackage

// File: rtl/sram_wait_cnt.sv
module sram_wait_cnt #(
  parameter int unsigned WAIT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WAIT_W-1:0] limit_i,
  input  logic              run_i,
  output logic              last_o
);
  logic [WAIT_W-1:0] cnt_q, lim_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else if (load_i) begin
      cnt_q <= '0;
      lim_q <= limit_i;
    end else if (run_i && !last_o) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign last_o = (cnt_q == lim_q);

  AST_WAIT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= lim_q) else $error("wait counter past limit"); // R2
endmodule

// File: rtl/sram_seq.sv
module sram_seq
  import sram_lane_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_valid_i,
  input  logic req_we_i,
  input  logic mask_zero_i,
  input  logic last_i,
  output logic req_ready_o,
  output logic load_o,
  output logic run_o,
  output logic we_q_o,
  output logic capture_o,
  output logic clear_o,
  output logic rsp_valid_o,
  output logic ce_no,
  output logic oe_no,
  output logic we_no
);
  seq_state_e state_q, state_d;
  logic we_q, rsp_q, accept;

  assign accept    = req_valid_i && (state_q == SEQ_IDLE);
  assign load_o    = accept && !mask_zero_i;
  assign clear_o   = accept && mask_zero_i && !req_we_i;
  assign run_o     = (state_q == SEQ_ACCESS);
  assign capture_o = run_o && last_i && !we_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE:   if (load_o) state_d = SEQ_ACCESS;
      SEQ_ACCESS: if (last_i) state_d = SEQ_IDLE;
      default:    state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      we_q    <= 1'b0;
      rsp_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (load_o) we_q <= req_we_i;
      rsp_q <= clear_o || capture_o;
    end
  end

  assign req_ready_o = (state_q == SEQ_IDLE);
  assign we_q_o      = we_q;
  assign rsp_valid_o = rsp_q;
  assign ce_no       = !run_o;
  assign oe_no       = !(run_o && !we_q);
  assign we_no       = !(run_o && we_q);
endmodule

// File: rtl/sram_lane.sv
module sram_lane #(
  parameter int unsigned LANE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              en_i,
  input  logic [LANE_W-1:0] wdata_i,
  input  logic              run_i,
  input  logic              we_i,
  input  logic              capture_i,
  input  logic              clear_i,
  input  logic [LANE_W-1:0] dq_i,
  output logic              be_no,
  output logic [LANE_W-1:0] dq_o,
  output logic              dq_oe_o,
  output logic [LANE_W-1:0] rdata_o
);
  logic              en_q;
  logic [LANE_W-1:0] wd_q, rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0;
      wd_q <= '0;
      rd_q <= '0;
    end else begin
      if (load_i) begin
        en_q <= en_i;
        wd_q <= wdata_i;
      end
      if (clear_i)        rd_q <= '0;
      else if (capture_i) rd_q <= en_q ? dq_i : '0;
    end
  end

  assign be_no   = !(run_i && en_q);
  assign dq_oe_o = run_i && we_i && en_q;
  assign dq_o    = wd_q;
  assign rdata_o = rd_q;
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned WAIT_W = 4,
  localparam int unsigned LANES = DATA_W / LANE_BITS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WAIT_W-1:0] wait_cfg_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [LANES-1:0]  req_mask_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic              sram_ce_no,
  output logic              sram_oe_no,
  output logic              sram_we_no,
  output logic [LANES-1:0]  sram_be_no,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic [LANES-1:0]  sram_dq_oe_o,
  input  logic [DATA_W-1:0] sram_dq_i
);
  logic load, run, we_q, capture, clear, last;
  logic [ADDR_W-1:0] addr_q;

  sram_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_we_i    (req_we_i),
    .mask_zero_i (req_mask_i == '0),
    .last_i      (last),
    .req_ready_o (req_ready_o),
    .load_o      (load),
    .run_o       (run),
    .we_q_o      (we_q),
    .capture_o   (capture),
    .clear_o     (clear),
    .rsp_valid_o (rsp_valid_o),
    .ce_no       (sram_ce_no),
    .oe_no       (sram_oe_no),
    .we_no       (sram_we_no)
  );

  sram_wait_cnt #(.WAIT_W(WAIT_W)) u_wait (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .limit_i (wait_cfg_i),
    .run_i   (run),
    .last_o  (last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   addr_q <= '0;
    else if (load) addr_q <= req_addr_i;
  end
  assign sram_addr_o = addr_q;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    sram_lane #(.LANE_W(LANE_BITS)) u_lane (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .load_i    (load),
      .en_i      (req_mask_i[l]),
      .wdata_i   (req_wdata_i[l*LANE_BITS +: LANE_BITS]),
      .run_i     (run),
      .we_i      (we_q),
      .capture_i (capture),
      .clear_i   (clear),
      .dq_i      (sram_dq_i[l*LANE_BITS +: LANE_BITS]),
      .be_no     (sram_be_no[l]),
      .dq_o      (sram_dq_o[l*LANE_BITS +: LANE_BITS]),
      .dq_oe_o   (sram_dq_oe_o[l]),
      .rdata_o   (rsp_rdata_o[l*LANE_BITS +: LANE_BITS])
    );
  end

  AST_DRIVE_ONLY_WE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|sram_dq_oe_o) |-> !sram_we_no) else $error("lane driven outside write"); // R6
  AST_NO_OE_WE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!sram_oe_no && !sram_we_no)) else $error("oe and we both low"); // R3
  AST_CE_LANES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_ce_no |-> !(&sram_be_no)) else $error("access with no lane"); // R5
  AST_WE_ADDR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_no |=> (sram_we_no || $stable(sram_addr_o))) else $error("addr moved under we"); // R10
  AST_READY_DESEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_ready_o && !load) |=> sram_ce_no) else $error("no deselect gap"); // R9
endmodule

// File: tb/sim_sram_lane_ctrl.sv
module sim_sram_lane_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  wait_cfg = '0;
  logic        valid = 1'b0, ready, we = 1'b0;
  logic [16:0] addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic [1:0]  mask = '0;
  logic        rsp_valid;
  logic [16:0] s_addr;
  logic        ce_n, oe_n, we_n;
  logic [1:0]  be_n, dq_oe;
  logic [15:0] dq_o, dq_i;

  int nvec = 0, nfail = 0;
  bit done = 1'b0;
  logic [15:0] mem [256];
  logic [15:0] sh  [256];

  always #10 clk = ~clk;

  sram_lane_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .wait_cfg_i(wait_cfg),
    .req_valid_i(valid), .req_ready_o(ready), .req_we_i(we),
    .req_addr_i(addr), .req_wdata_i(wdata), .req_mask_i(mask),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rdata),
    .sram_addr_o(s_addr), .sram_ce_no(ce_n), .sram_oe_no(oe_n),
    .sram_we_no(we_n), .sram_be_no(be_n), .sram_dq_o(dq_o),
    .sram_dq_oe_o(dq_oe), .sram_dq_i(dq_i)
  );

  // behavioural memory: undriven read lanes return 0xA5
  wire rd_on = !ce_n && !oe_n && we_n;
  assign dq_i = {(rd_on && !be_n[1]) ? mem[s_addr[16:9]][15:8] : 8'hA5,
                 (rd_on && !be_n[0]) ? mem[s_addr[16:9]][7:0]  : 8'hA5};

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= '0;
    end else if (!ce_n && !we_n) begin
      for (int l = 0; l < 2; l++)
        if (!be_n[l] && dq_oe[l]) mem[s_addr[16:9]][l*8 +: 8] <= dq_o[l*8 +: 8];
    end
  end

  function automatic logic [16:0] addr_of(int idx);
    logic [7:0] b = idx[7:0];
    return {b, ~b, b[0]};
  endfunction

  function automatic logic [15:0] lane_mask(logic [1:0] m);
    return {{8{m[1]}}, {8{m[0]}}};
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_req(bit w, int idx, logic [15:0] wd, logic [1:0] m, int n);
    int ces = 0, rsps = 0;
    logic [15:0] rd = '0;
    logic [15:0] exp;
    bit fld_ok = 1'b1, adr_ok = 1'b1;
    logic [31:0] fld_act = '0, fld_exp = '0;
    @(negedge clk);
    valid = 1'b1; we = w; addr = addr_of(idx); wdata = wd; mask = m; wait_cfg = n[3:0];
    @(negedge clk);
    valid = 1'b0; wait_cfg = 4'($urandom);
    forever begin
      if (!ce_n) begin
        ces++;
        if (!({be_n, oe_n, we_n, dq_oe, ready} == {~m, w, !w, (w ? m : 2'b00), 1'b0})) begin
          fld_ok = 1'b0;
          fld_act = {24'd0, be_n, oe_n, we_n, dq_oe, ready};
          fld_exp = {24'd0, ~m, w, !w, (w ? m : 2'b00), 1'b0};
        end
        if (s_addr != addr_of(idx)) adr_ok = 1'b0;
      end
      if (rsp_valid) begin rsps++; rd = rdata; end
      if (ready && ce_n) break;
      @(negedge clk);
    end
    if (m != 2'b00) begin
      chk(fld_ok, w ? "R4/R5/R6/R9" : "R3/R5/R6/R9", "strobes during access", fld_act, fld_exp);
      chk(adr_ok, "R10", "address during access", 32'(s_addr), 32'(addr_of(idx)));
    end
    chk(ces == ((m != 0) ? n + 1 : 0), (m != 0) ? "R2" : "R8", "chip enable clocks",
        32'(ces), 32'((m != 0) ? n + 1 : 0));
    chk(rsps == (w ? 0 : 1), w ? "R8" : "R3", "response pulses", 32'(rsps), 32'(w ? 0 : 1));
    if (!w) begin
      exp = sh[idx] & lane_mask(m);
      chk(rd == exp, (m == 0) ? "R8" : "R7", "read data", 32'(rd), 32'(exp));
    end else begin
      sh[idx] = (sh[idx] & ~lane_mask(m)) | (wd & lane_mask(m));
    end
    @(negedge clk);
    chk(!rsp_valid && ce_n && ready && dq_oe == 2'b00, "R3/R9", "idle after access",
        {28'd0, rsp_valid, ce_n, dq_oe}, {28'd0, 1'b0, 1'b1, 2'b00});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) sh[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({ce_n, oe_n, we_n, be_n, dq_oe, ready, rsp_valid} == 9'b111_11_00_1_0, "R1", "reset state",
        {23'd0, ce_n, oe_n, we_n, be_n, dq_oe, ready, rsp_valid}, 32'b111_11_00_1_0);
    // directed corners
    do_req(1'b1, 1, 16'h1234, 2'b11, 0);   // R4 word write, minimum wait
    do_req(1'b0, 1, 16'h0,    2'b11, 0);   // R3 word read
    do_req(1'b1, 2, 16'hBEEF, 2'b11, 15);  // R2 maximum wait
    do_req(1'b1, 2, 16'h00C3, 2'b01, 15);  // R5 lower byte only
    do_req(1'b1, 2, 16'h7700, 2'b10, 3);   // R5 upper byte only
    do_req(1'b0, 2, 16'h0,    2'b11, 15);
    do_req(1'b0, 2, 16'h0,    2'b01, 2);   // R7 upper zeroed
    do_req(1'b0, 2, 16'h0,    2'b10, 5);   // R7 lower zeroed
    do_req(1'b1, 2, 16'hFFFF, 2'b00, 4);   // R8 zero-mask write
    do_req(1'b0, 2, 16'h0,    2'b00, 4);   // R8 zero-mask read
    do_req(1'b0, 2, 16'h0,    2'b11, 1);   // R8 memory untouched
    for (int k = 0; k < 300; k++)
      do_req(1'($urandom), int'($urandom % 16), 16'($urandom), 2'($urandom),
             int'($urandom % 8));
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    nvec++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule